// File: doc/BRIEF.md
# Two-Wire Bus Slave with Command Pointer

This block is a slave on an open-drain two-wire serial bus. It runs on a fast system clock that oversamples the clock line (SCL) and the data line (SDA) through a two-flop synchronizer. On its own it finds bus framing (Start and Stop), compares the incoming device address with a fixed 7-bit value, and answers only when the two match. SDA is never driven high. The block pulls the line low by raising `sda_oe`.

Once the address is accepted for a write, the first byte is taken as a command. It loads a register pointer and writes nothing. Every later write byte goes out on a one-cycle register write port at the pointer, and the pointer then advances. A read needs a write phase that sets the pointer first, followed by a repeated Start carrying a read address. The slave then returns the register at the pointer, one byte at a time, and keeps doing so for as long as the master acknowledges. The master decides how many bytes follow the address. There is no upper limit.

Top module: `smbus_cmd_slave`

## Requirements
- R1: Out of reset `sda_oe` and `reg_we` are 0. A Start (SDA falling while SCL is high) begins reception of an address byte from any state.
- R2: A Stop (SDA rising while SCL is high) returns the slave to idle. From then on SDA is released until the next Start.
- R3: Bits are sampled on the SCL high phase and shifted MSB first. The slave changes `sda_oe` only while SCL is low, so the level it presents stays constant through each SCL high phase.
- R4: The address byte is 7 address bits followed by a direction bit, where 1 means read and 0 means write. When the address bits equal 0011011, the slave holds SDA low through the whole high phase of the ninth clock. When they do not, the slave never pulls SDA low and writes nothing until the next Start or Stop.
- R5: The first byte after an accepted write address loads the register pointer from its low PTR_W bits. The slave acknowledges it and does not raise `reg_we`.
- R6: Each later write byte is acknowledged and raises `reg_we` for one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments and wraps modulo 2^PTR_W. The number of such bytes is unlimited.
- R7: After an accepted read address, the slave drives `reg_rdata` at the pointer MSB first, beginning at the SCL low phase that follows the address acknowledge. It releases SDA during the master's acknowledge slot.
- R8: The pointer advances after each byte read. If the master acknowledges, the next byte comes from the new pointer. If the master does not acknowledge, SDA stays released until the next Start or Stop.
- R9: A Start in the middle of a byte abandons that byte and clears the bit count, and address matching starts over.
- R10: A repeated Start followed by a read address keeps the pointer that the earlier command byte loaded, including any increments since then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | PTR_W | Register pointer, used for both write and read |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The data patterns are asymmetric, for example A5 and 3C, so a reversed bit order or a one-bit slip in the shifter gives a visibly different result. Several traffic patterns are run. A matching write against a non-matching address separates acknowledge decisions from address decoding. A read that ends in an acknowledge and then a refusal, followed by one extra clocked byte, separates pointer advance from the release rule. A command of 0x0F followed by three writes and a read-back shows the pointer wrapping and surviving a repeated Start. A Start issued after half an address byte confirms that stale bits are thrown away.

// File: rtl/smbus_pkg.sv
package smbus_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } smb_state_e;

  // Upper seven bits of the first byte carry the device address.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // Bit 0 of the first byte: 1 selects read.
  function automatic logic is_read(input logic [7:0] b);
    return b[0];
  endfunction
endpackage

// File: rtl/smb_sync2.sv
module smb_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // Idle bus level is high, so both stages reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  // Framing events need SCL high on both samples around the SDA edge.
  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smbus_cmd_slave.sv
module smbus_cmd_slave
  import smbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0011011,
  parameter int         PTR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);

  // Named internal events, visible to the bound checker.
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic byte_full, wr_evt;

  smb_state_e       state;
  logic [CNT_W-1:0] bcnt;
  logic [7:0]       sr;
  logic [PTR_W-1:0] ptr;
  logic             rw;
  logic             mnack;

  smb_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i}),
    .q     ({scl_s, sda_s})
  );

  smb_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_s),
    .sda       (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign byte_full = (bcnt == FULL_CNT);
  assign wr_evt    = (state == ST_WDATA) && scl_fall && byte_full;

  assign reg_we    = wr_evt;
  assign reg_wdata = sr;
  assign reg_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      sr     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mnack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            sr   <= {sr[6:0], sda_s};
            bcnt <= bcnt + 1'b1;
          end else if (scl_fall && byte_full) begin
            bcnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit(sr, DEV_ADDR)) begin
                rw     <= is_read(sr);
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_SKIP;
              end
            end else if (state == ST_CMD) begin
              ptr    <= sr[PTR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_CMD_ACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              sr     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && !byte_full) begin
            bcnt <= bcnt + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              bcnt   <= '0;
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b0;
              state  <= ST_RDATA_ACK;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            mnack <= sda_s;
          end else if (scl_fall) begin
            if (mnack) begin
              state <= ST_SKIP;
            end else begin
              sr     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= ST_RDATA;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/smbus_cmd_slave_chk.sv
module smbus_cmd_slave_chk
  import smbus_pkg::*;
#(
  parameter int PTR_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr,
  input logic [CNT_W-1:0] bcnt,
  input smb_state_e       state
);
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (bcnt == '0) && !sda_oe && (state == ST_ADDR));

  assert_start_enters_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> state == ST_ADDR);

  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe && (state == ST_IDLE));

  assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_write_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> sda_oe);

  assert_ptr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 1'b1);

  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !reg_we);
endmodule

bind smbus_cmd_slave smbus_cmd_slave_chk #(
  .PTR_W (PTR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .bcnt      (bcnt),
  .state     (state)
);

// File: tb/smbus_cmd_slave_tb.sv
`timescale 1ns/1ps
module smbus_cmd_slave_tb;
  localparam int PTR_W = 4;
  localparam int Q     = 10;
  localparam logic [7:0] AW = 8'h36;  // 0011011 + write
  localparam logic [7:0] AR = 8'h37;  // 0011011 + read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [PTR_W-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [2**PTR_W];
  int n_chk = 0, n_fail = 0, n_wr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smbus_cmd_slave #(.PTR_W(PTR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];
  always_ff @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    n_wr <= n_wr + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); a1 = sda_line; wq(); a2 = sda_line;
    scl = 1'b0; wq();
    ack = !a1 && !a2;
  endtask

  task automatic m_rbyte(input bit mack, output logic [7:0] d, output bit steady);
    logic s1, s2;
    steady = 1'b1; d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); s1 = sda_line; wq(); s2 = sda_line;
      if (s1 != s2) steady = 1'b0;
      d = {d[6:0], s1};
      scl = 1'b0; wq();
    end
    sda_m = !mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(reg_we == 1'b0, "R1 reset reg_we", reg_we, 0);
  endtask

  task automatic t_write();
    bit a; int w0 = n_wr;
    m_start(); m_wbyte(AW, a); check(a, "R4 address ack", a, 1);
    m_wbyte(8'h03, a); check(a, "R5 command ack", a, 1);
    check(n_wr == w0, "R5 command not written", n_wr - w0, 0);
    m_wbyte(8'hA5, a); check(a, "R6 data ack", a, 1);
    m_wbyte(8'h3C, a); check(a, "R6 data ack 2", a, 1);
    m_stop(); wq();
    check(mem[3] == 8'hA5, "R6 R3 mem[3]", mem[3], 8'hA5);
    check(mem[4] == 8'h3C, "R6 mem[4]", mem[4], 8'h3C);
    check(n_wr - w0 == 2, "R6 write count", n_wr - w0, 2);
    check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
  endtask

  task automatic t_bad_addr();
    bit a; int w0 = n_wr;
    m_start(); m_wbyte(8'h38, a); check(!a, "R4 mismatch nack", a, 0);
    m_wbyte(8'h02, a); check(!a, "R4 ignored byte nack", a, 0);
    m_wbyte(8'hEE, a); check(!a, "R4 ignored byte nack 2", a, 0);
    m_stop(); wq();
    check(n_wr == w0, "R4 no writes", n_wr - w0, 0);
  endtask

  task automatic t_read();
    bit a, st; logic [7:0] d;
    m_start(); m_wbyte(AW, a); m_wbyte(8'h03, a);
    m_start(); m_wbyte(AR, a); check(a, "R7 read address ack", a, 1);
    m_rbyte(1'b1, d, st);
    check(d == 8'hA5, "R7 R3 first read", d, 8'hA5);
    check(st, "R3 sda steady while scl high", st, 1);
    m_rbyte(1'b0, d, st);
    check(d == 8'h3C, "R8 read after ack", d, 8'h3C);
    m_rbyte(1'b0, d, st);
    check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    m_stop(); wq();
    check(sda_oe == 1'b0, "R2 idle after read", sda_oe, 0);
  endtask

  task automatic t_wrap();
    bit a, st; logic [7:0] d;
    m_start(); m_wbyte(AW, a); m_wbyte(8'h0F, a);
    m_wbyte(8'h11, a); m_wbyte(8'h22, a); m_wbyte(8'h33, a); m_stop(); wq();
    check(mem[15] == 8'h11 && mem[0] == 8'h22 && mem[1] == 8'h33, "R6 wrap",
          {mem[15], mem[0], mem[1]}, 24'h112233);
    m_start(); m_wbyte(AW, a); m_wbyte(8'h0F, a);
    m_start(); m_wbyte(AR, a);
    m_rbyte(1'b1, d, st); check(d == 8'h11, "R10 pointer kept", d, 8'h11);
    m_rbyte(1'b1, d, st); check(d == 8'h22, "R8 R10 wrap read", d, 8'h22);
    m_rbyte(1'b0, d, st); check(d == 8'h33, "R8 third read", d, 8'h33);
    m_stop(); wq();
  endtask

  task automatic t_abort();
    bit a; int w0 = n_wr;
    m_start(); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
    m_start(); m_wbyte(AW, a); check(a, "R9 address after abort", a, 1);
    m_wbyte(8'h05, a); m_wbyte(8'h77, a); m_stop(); wq();
    check(mem[5] == 8'h77, "R9 write after abort", mem[5], 8'h77);
    check(n_wr - w0 == 1, "R9 single write", n_wr - w0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**PTR_W; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wq();
    t_write();
    t_bad_addr();
    t_read();
    t_wrap();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule